// File: doc/BRIEF.md
# Read-Request Issue and Bus Turnaround Controller

This block sits on the processor side of a system interface in which a command bus and a shared address/data bus are multiplexed between the processor and an external agent. It takes an internal read request with its physical address and waits until the agent signals that it can accept a read. While the controller owns the interface, it puts the read command and the address on the two buses in the same cycle and pulses a valid strobe. It then hands ownership of both buses to the agent, so that the agent can return the response.

The handoff is timed by the agent's active-low release strobe. The controller keeps driving both buses until release is sampled low, which may already happen during the issue cycle. One cycle later it turns its drivers off. That leaves the agent a turnaround cycle before it drives the buses. Only one read may be outstanding at a time. Ownership comes back to the controller when the agent places the null command on the command bus. While a read is outstanding, an external-request strobe from the agent is recorded as pending. It is never taken as a response and does not change the handoff.

Top module: `rdhand_ctrl`

## Requirements
- R1: After reset the controller owns the interface (`is_master`=1). `valid_out_n` is 1, `bus_oe` is 0, `busy` is 0 and `ext_pending` is 0.
- R2: A read is not issued while `agt_rd_ready_n` is 1. In that case `bus_oe` stays 0, `valid_out_n` stays 1 and `busy` stays 0.
- R3: When `rd_req`=1 and `agt_rd_ready_n`=0 are sampled while the controller is master and idle, the next cycle is the issue cycle. In it `bus_oe`=1, `cmd_out` carries READ (code 1) and `ad_out` carries the captured `rd_addr`. `valid_out_n` is 0 in that cycle only.
- R4: `bus_oe` stays 1, with the captured address held, until `agt_release_n` is sampled 0. In the cycle after that sample `bus_oe` is 0. A release sampled during the issue cycle counts.
- R5: With the default EARLY_SLAVE=0, `is_master` stays 1 through the issue cycle and while driving. It falls in the same cycle that `bus_oe` falls.
- R6: `agt_ext_req_n`=0 sampled while a read is outstanding sets `ext_pending`. It neither ends the bus drive nor returns the controller to master.
- R7: While a read is outstanding, `busy`=1 and any new `rd_req` is ignored. In the slave state, command-bus values other than NULL are ignored.
- R8: NULL (code 3) sampled on `cmd_in` in the slave state returns the controller to master in the next cycle, with `busy`=0 and `ext_pending`=0. Command encodings are: 0 idle, 1 READ, 2 WRITE, 3 NULL, 4 non-final data id, 5 final data id.
- R9: Whenever `bus_oe` is 0, `cmd_out` and `ad_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Internal read request |
| rd_addr | input | AW | Physical address of the request |
| busy | output | 1 | A read is outstanding; a new request stalls |
| agt_rd_ready_n | input | 1 | Agent can accept a read (active low) |
| agt_release_n | input | 1 | Agent release strobe (active low) |
| agt_ext_req_n | input | 1 | Agent external-request strobe (active low) |
| cmd_in | input | CW | Command bus as driven by the agent |
| cmd_out | output | CW | Command bus drive value |
| ad_out | output | AW | Address/data bus drive value |
| bus_oe | output | 1 | Output enable for both buses |
| valid_out_n | output | 1 | Valid strobe for the issue cycle (active low) |
| is_master | output | 1 | Controller owns the interface |
| ext_pending | output | 1 | External request recorded during the read |

## Verification
On every cycle the assertions check three things. The valid strobe lasts a single cycle and only comes with the read command on enabled buses. The drivers turn off one cycle after release and never before it, with the address held steady in between. A missing read-ready or an external-request strobe never starts or ends a drive. Some behaviour can only be shown by the bench's scenarios. These are the exact issue cycle, the address value captured, a release that lands in the issue cycle itself, how the master flag follows the handoff, junk commands being ignored in the slave state, and the return to master on NULL with the pending flag cleared.

// File: rtl/rdhand_ctrl.sv
module rdhand_ctrl #(
  parameter int AW = 32,
  parameter int CW = 4,
  parameter bit EARLY_SLAVE = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_req,
  input  logic [AW-1:0] rd_addr,
  output logic          busy,
  input  logic          agt_rd_ready_n,
  input  logic          agt_release_n,
  input  logic          agt_ext_req_n,
  input  logic [CW-1:0] cmd_in,
  output logic [CW-1:0] cmd_out,
  output logic [AW-1:0] ad_out,
  output logic          bus_oe,
  output logic          valid_out_n,
  output logic          is_master,
  output logic          ext_pending
);

  localparam logic [CW-1:0] C_IDLE  = CW'(0);
  localparam logic [CW-1:0] C_READ  = CW'(1);
  localparam logic [CW-1:0] C_WRITE = CW'(2);
  localparam logic [CW-1:0] C_NULL  = CW'(3);
  localparam logic [CW-1:0] C_NDAT  = CW'(4);
  localparam logic [CW-1:0] C_LDAT  = CW'(5);

  typedef enum logic [1:0] {S_MASTER, S_ISSUE, S_HOLD, S_SLAVE} st_t;

  st_t           st;
  logic [AW-1:0] addr_q;
  logic          accept;

  assign accept = (st == S_MASTER) && rd_req && !agt_rd_ready_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_MASTER;
      addr_q      <= '0;
      ext_pending <= 1'b0;
    end else begin
      case (st)
        S_MASTER: if (accept) begin
          st     <= S_ISSUE;
          addr_q <= rd_addr;
        end
        S_ISSUE:  st <= agt_release_n ? S_HOLD : S_SLAVE;
        S_HOLD:   if (!agt_release_n) st <= S_SLAVE;
        S_SLAVE:  if (cmd_in == C_NULL) st <= S_MASTER;
        default:  st <= S_MASTER;
      endcase
      if (st == S_SLAVE && cmd_in == C_NULL)
        ext_pending <= 1'b0;
      else if (st != S_MASTER && !agt_ext_req_n)
        ext_pending <= 1'b1;
    end
  end

  assign bus_oe      = (st == S_ISSUE) || (st == S_HOLD);
  assign valid_out_n = (st != S_ISSUE);
  assign busy        = (st != S_MASTER);
  assign cmd_out     = bus_oe ? C_READ : C_IDLE;
  assign ad_out      = bus_oe ? addr_q : '0;

  generate
    if (EARLY_SLAVE) begin : g_early
      assign is_master = (st == S_MASTER);
    end else begin : g_late
      assign is_master = (st != S_SLAVE);
    end
  endgenerate

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_out_n |=> valid_out_n); // R3
  AST_VALID_WITH_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_out_n |-> (bus_oe && cmd_out == C_READ)); // R3
  AST_NO_ISSUE_UNREADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_oe && agt_rd_ready_n) |=> valid_out_n); // R2
  AST_OE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && !agt_release_n) |=> !bus_oe); // R4
  AST_OE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && agt_release_n) |=> (bus_oe && $stable(ad_out))); // R4
  AST_EXT_NO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && !agt_ext_req_n && agt_release_n) |=> bus_oe); // R6
  AST_EXT_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !agt_ext_req_n && cmd_in != C_NULL) |=> ext_pending); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> (cmd_out == C_IDLE && ad_out == '0)); // R9
  AST_UNUSED_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_out != C_WRITE && cmd_out != C_NDAT && cmd_out != C_LDAT); // R8

endmodule

// File: tb/rdhand_ctrl_test.sv
module rdhand_ctrl_test;
  localparam int AW = 32;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_req = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic          busy;
  logic          agt_rd_ready_n = 1'b1;
  logic          agt_release_n = 1'b1;
  logic          agt_ext_req_n = 1'b1;
  logic [CW-1:0] cmd_in = '0;
  logic [CW-1:0] cmd_out;
  logic [AW-1:0] ad_out;
  logic          bus_oe, valid_out_n, is_master, ext_pending;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  integer seed = 1234;

  always #4 clk = ~clk;

  rdhand_ctrl #(.AW(AW), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr), .busy(busy),
    .agt_rd_ready_n(agt_rd_ready_n), .agt_release_n(agt_release_n),
    .agt_ext_req_n(agt_ext_req_n), .cmd_in(cmd_in), .cmd_out(cmd_out),
    .ad_out(ad_out), .bus_oe(bus_oe), .valid_out_n(valid_out_n),
    .is_master(is_master), .ext_pending(ext_pending)
  );

  function automatic int rnd(int n);
    return int'($unsigned($random(seed)) % n);
  endfunction

  function automatic logic [CW-1:0] junk_cmd();
    logic [CW-1:0] c;
    c = CW'(rnd(16));
    if (c == CW'(3)) c = CW'(5);
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_idle_master(input string req);
    chk(is_master == 1'b1, {req, " is_master"}, is_master, 1);
    chk(bus_oe == 1'b0, {req, " bus_oe"}, bus_oe, 0);
    chk(valid_out_n == 1'b1, {req, " valid_out_n"}, valid_out_n, 1);
    chk(busy == 1'b0, {req, " busy"}, busy, 0);
    chk(cmd_out == '0 && ad_out == '0, {req, " quiet bus"}, ad_out, 0);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input int rdy_wait, input int rel_wait,
                         input int ext_at, input int junk);
    rd_req = 1'b1;
    rd_addr = a;
    for (int i = 0; i < rdy_wait; i++) begin
      @(negedge clk);
      chk(bus_oe == 1'b0 && valid_out_n == 1'b1 && busy == 1'b0, "R2 no issue unready", bus_oe, 0);
    end
    agt_rd_ready_n = 1'b0;
    @(negedge clk);
    chk(bus_oe == 1'b1, "R3 oe in issue", bus_oe, 1);
    chk(valid_out_n == 1'b0, "R3 valid strobe", valid_out_n, 0);
    chk(cmd_out == CW'(1), "R3 read cmd", cmd_out, 1);
    chk(ad_out == a, "R3 address", ad_out, a);
    chk(is_master == 1'b1, "R5 master in issue", is_master, 1);
    agt_rd_ready_n = 1'b1;
    rd_addr = ~a;
    for (int i = 0; i < rel_wait; i++) begin
      if (i == ext_at) agt_ext_req_n = 1'b0;
      @(negedge clk);
      agt_ext_req_n = 1'b1;
      chk(bus_oe == 1'b1 && ad_out == a, "R4 hold drive", ad_out, a);
      chk(valid_out_n == 1'b1, "R3 strobe single", valid_out_n, 1);
      chk(busy == 1'b1, "R7 busy while driving", busy, 1);
      chk(is_master == 1'b1, "R5 master while driving", is_master, 1);
      if (i == ext_at)
        chk(ext_pending == 1'b1, "R6 ext recorded, drive kept", ext_pending, 1);
    end
    agt_release_n = 1'b0;
    @(negedge clk);
    agt_release_n = 1'b1;
    chk(bus_oe == 1'b0, "R4 oe off after release", bus_oe, 0);
    chk(is_master == 1'b0, "R5 slave with drive off", is_master, 0);
    chk(cmd_out == '0 && ad_out == '0, "R9 quiet after release", ad_out, 0);
    for (int i = 0; i < junk; i++) begin
      cmd_in = junk_cmd();
      if (i == 0 && ext_at < 0) agt_ext_req_n = 1'b0;
      @(negedge clk);
      agt_ext_req_n = 1'b1;
      chk(is_master == 1'b0 && busy == 1'b1, "R7 junk ignored in slave", is_master, 0);
      chk(bus_oe == 1'b0, "R6 ext no return", bus_oe, 0);
      if (i == 0 && ext_at < 0)
        chk(ext_pending == 1'b1, "R6 ext in slave", ext_pending, 1);
    end
    cmd_in = CW'(3);
    rd_req = 1'b0;
    @(negedge clk);
    cmd_in = '0;
    chk_idle_master("R8 null return");
    chk(ext_pending == 1'b0, "R8 pending cleared", ext_pending, 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk_idle_master("R1 reset");
    chk(ext_pending == 1'b0, "R1 pending", ext_pending, 0);

    do_read(32'hDEAD_BEEF, 4, 0, -1, 0);
    do_read(32'h0000_0001, 0, 3, 1, 2);
    do_read(32'hFFFF_FFFF, 2, 5, -2, 0);
    agt_ext_req_n = 1'b0;
    @(negedge clk);
    agt_ext_req_n = 1'b1;
    chk(ext_pending == 1'b0 && is_master == 1'b1, "R6 ext idle master", ext_pending, 0);

    for (int t = 0; t < 60; t++) begin
      int e;
      e = (rnd(3) == 0) ? -1 : rnd(6);
      do_read($unsigned($random(seed)), rnd(4), rnd(6), e, rnd(4));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule